// File: doc/BRIEF.md
# Micro-op Aware Fetch PC Sequencer

This block keeps the fetch position of one hardware thread on a processor whose instruction set has branch delay slots and whose decoder breaks some instructions into a series of micro-operations. The position is a triple: the address being fetched, the address after it, and a micro-operation index inside the current macro-instruction. Each cycle the fetch logic presents the attributes of the instruction it has just decoded: whether it changes control flow, whether it is a micro-operation and whether it is the final one, plus a taken prediction and a target. The sequencer produces the predicted triple for that instruction, and on the next edge it moves to that triple. It also reports whether the position inside the current cache line may move on.

Redirects reload the triple. A thread-removal request has the highest priority, then a commit squash carrying a full triple, then a decode squash carrying only a branch target. A separate resolution port compares a recorded predicted triple with the resolved one and reports, one cycle later, whether any of the three fields disagree and which ones.

Top module: `ufetch_seq`

## Requirements
- R1: After reset the address, next address and micro index are all 0, and the mispredict flag and field mask are 0.
- R2: A step that is not control flow, is a micro-operation and is not the last one keeps the address and next address, adds 1 to the 8-bit micro index (wrapping), and holds line_step at 0.
- R3: A step that is not control flow and is not a mid-sequence micro-operation moves the address to the old next address, adds 4 to the next address, clears the micro index, and raises line_step.
- R4: A control-flow step always clears the micro index, even when it is flagged as a non-final micro-operation; when not predicted taken it advances the address pair as in R3.
- R5: A control-flow step predicted taken moves the address to the old next address (the delay slot) and loads the next address with the target.
- R6: While step_valid is high, pred_pc, pred_npc and pred_upc show in the same cycle the triple the step produces, and the state takes that triple on the next edge unless a redirect is present.
- R7: A commit squash loads the address, next address and micro index from its bundle on the next edge; it overrides a decode squash and a step in the same cycle, and a step lost to any redirect leaves line_step at 0.
- R8: A decode squash without a commit squash or removal sets the address to the target, the next address to the target plus 4 and the micro index to 0, and overrides a step.
- R9: A thread-removal request sets the address to 0, the next address to 4 and the micro index to 0, overriding every other input.
- R10: One cycle after res_valid, mispredict is 1 when any field of the predicted triple differs from the resolved one; mis_fields bit 0 marks the address, bit 1 the next address, bit 2 the micro index; both are 0 one cycle after a cycle without res_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rm_valid | input | 1 | Thread removal request |
| cmt_sq_valid | input | 1 | Commit squash strobe |
| cmt_pc | input | 32 | Commit squash address |
| cmt_npc | input | 32 | Commit squash next address |
| cmt_upc | input | 8 | Commit squash micro index |
| dec_sq_valid | input | 1 | Decode squash strobe |
| dec_target | input | 32 | Decode squash branch target |
| step_valid | input | 1 | A decoded instruction is presented |
| step_is_ctrl | input | 1 | Instruction changes control flow |
| step_is_micro | input | 1 | Instruction is a micro-operation |
| step_is_last | input | 1 | Instruction is the final micro-operation |
| step_taken | input | 1 | Branch predicted taken |
| step_target | input | 32 | Predicted branch target |
| res_valid | input | 1 | Resolution strobe |
| res_pred_pc | input | 32 | Recorded predicted address |
| res_pred_npc | input | 32 | Recorded predicted next address |
| res_pred_upc | input | 8 | Recorded predicted micro index |
| res_act_pc | input | 32 | Resolved address |
| res_act_npc | input | 32 | Resolved next address |
| res_act_upc | input | 8 | Resolved micro index |
| cur_pc | output | 32 | Current fetch address |
| cur_npc | output | 32 | Current next address |
| cur_upc | output | 8 | Current micro index |
| pred_pc | output | 32 | Predicted address after the step |
| pred_npc | output | 32 | Predicted next address after the step |
| pred_upc | output | 8 | Predicted micro index after the step |
| line_step | output | 1 | Offset inside the cache line may advance |
| mispredict | output | 1 | Registered mispredict flag |
| mis_fields | output | 3 | Registered per-field mismatch mask |

## Verification
On every cycle the assertions check the state update for each kind of step, the three redirect kinds and their priority, the line_step hold during a macro expansion, and the one-cycle mispredict relation to the compared fields. Only the bench scenarios show whole sequences: a macro expansion followed by its last micro-operation, a taken branch followed by its delay slot and the target, the predicted outputs matching the later state, and mismatches confined to a single field such as the micro index alone.

// File: rtl/ufs_pkg.sv
package ufs_pkg;
  localparam int PC_W       = 32;
  localparam int UPC_W      = 8;
  localparam int INSN_BYTES = 4;
  localparam int NFIELDS    = 3;

  typedef struct packed {
    logic [PC_W-1:0]  pc;
    logic [PC_W-1:0]  npc;
    logic [UPC_W-1:0] upc;
  } ftrip_t;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_STEP   = 3'd1,
    SRC_DEC    = 3'd2,
    SRC_CMT    = 3'd3,
    SRC_REMOVE = 3'd4
  } src_t;

  // Address of the following instruction slot.
  function automatic logic [PC_W-1:0] pc_after(input logic [PC_W-1:0] a);
    return a + PC_W'(INSN_BYTES);
  endfunction

  // Advance the micro index inside one macro-instruction.
  function automatic logic [UPC_W-1:0] upc_after(input logic [UPC_W-1:0] u);
    return u + UPC_W'(1);
  endfunction

  // Plain sequential advance of a triple.
  function automatic ftrip_t seq_advance(input ftrip_t t);
    ftrip_t r;
    r.pc  = t.npc;
    r.npc = pc_after(t.npc);
    r.upc = '0;
    return r;
  endfunction
endpackage

// File: rtl/ufs_step_calc.sv
module ufs_step_calc
  import ufs_pkg::*;
(
  input  ftrip_t          cur,
  input  logic            is_ctrl,
  input  logic            is_micro,
  input  logic            is_last,
  input  logic            taken,
  input  logic [PC_W-1:0] target,
  output ftrip_t          nxt,
  output logic            mid_macro
);
  always_comb begin
    mid_macro = is_micro && !is_last && !is_ctrl;
    nxt       = seq_advance(cur);
    if (is_ctrl) begin
      // control flow always lands at the start of a macro-instruction
      if (taken) begin
        nxt.pc  = cur.npc;
        nxt.npc = target;
      end
      nxt.upc = '0;
    end else if (mid_macro) begin
      nxt.pc  = cur.pc;
      nxt.npc = cur.npc;
      nxt.upc = upc_after(cur.upc);
    end
  end
endmodule

// File: rtl/ufs_redirect.sv
module ufs_redirect
  import ufs_pkg::*;
(
  input  logic            rm_valid,
  input  logic            cmt_valid,
  input  ftrip_t          cmt_trip,
  input  logic            dec_valid,
  input  logic [PC_W-1:0] dec_target,
  input  logic            step_valid,
  input  ftrip_t          step_trip,
  output ftrip_t          load_trip,
  output src_t            src
);
  always_comb begin
    load_trip = step_trip;
    src       = SRC_NONE;
    if (rm_valid) begin
      src           = SRC_REMOVE;
      load_trip.pc  = '0;
      load_trip.npc = pc_after('0);
      load_trip.upc = '0;
    end else if (cmt_valid) begin
      src       = SRC_CMT;
      load_trip = cmt_trip;
    end else if (dec_valid) begin
      src           = SRC_DEC;
      load_trip.pc  = dec_target;
      load_trip.npc = pc_after(dec_target);
      load_trip.upc = '0;
    end else if (step_valid) begin
      src = SRC_STEP;
    end
  end
endmodule

// File: rtl/ufs_resolve.sv
module ufs_resolve
  import ufs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_valid,
  input  ftrip_t             pred,
  input  ftrip_t             act,
  output logic               mispredict,
  output logic [NFIELDS-1:0] mis_fields
);
  logic [NFIELDS-1:0] diff;

  always_comb begin
    diff[0] = pred.pc  != act.pc;
    diff[1] = pred.npc != act.npc;
    diff[2] = pred.upc != act.upc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mispredict <= 1'b0;
      mis_fields <= '0;
    end else if (res_valid) begin
      mispredict <= |diff;
      mis_fields <= diff;
    end else begin
      mispredict <= 1'b0;
      mis_fields <= '0;
    end
  end
endmodule

// File: rtl/ufetch_seq.sv
module ufetch_seq
  import ufs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rm_valid,
  input  logic               cmt_sq_valid,
  input  logic [PC_W-1:0]    cmt_pc,
  input  logic [PC_W-1:0]    cmt_npc,
  input  logic [UPC_W-1:0]   cmt_upc,
  input  logic               dec_sq_valid,
  input  logic [PC_W-1:0]    dec_target,
  input  logic               step_valid,
  input  logic               step_is_ctrl,
  input  logic               step_is_micro,
  input  logic               step_is_last,
  input  logic               step_taken,
  input  logic [PC_W-1:0]    step_target,
  input  logic               res_valid,
  input  logic [PC_W-1:0]    res_pred_pc,
  input  logic [PC_W-1:0]    res_pred_npc,
  input  logic [UPC_W-1:0]   res_pred_upc,
  input  logic [PC_W-1:0]    res_act_pc,
  input  logic [PC_W-1:0]    res_act_npc,
  input  logic [UPC_W-1:0]   res_act_upc,
  output logic [PC_W-1:0]    cur_pc,
  output logic [PC_W-1:0]    cur_npc,
  output logic [UPC_W-1:0]   cur_upc,
  output logic [PC_W-1:0]    pred_pc,
  output logic [PC_W-1:0]    pred_npc,
  output logic [UPC_W-1:0]   pred_upc,
  output logic               line_step,
  output logic               mispredict,
  output logic [NFIELDS-1:0] mis_fields
);
  ftrip_t state_q;
  ftrip_t step_trip;
  ftrip_t load_trip;
  ftrip_t cmt_trip;
  ftrip_t res_pred;
  ftrip_t res_act;
  src_t   sel_src;

  // named events for the checker
  logic evt_mid_macro;
  logic evt_redirect;

  assign cmt_trip = '{pc: cmt_pc, npc: cmt_npc, upc: cmt_upc};
  assign res_pred = '{pc: res_pred_pc, npc: res_pred_npc, upc: res_pred_upc};
  assign res_act  = '{pc: res_act_pc, npc: res_act_npc, upc: res_act_upc};

  ufs_step_calc u_calc (
    .cur       (state_q),
    .is_ctrl   (step_is_ctrl),
    .is_micro  (step_is_micro),
    .is_last   (step_is_last),
    .taken     (step_taken),
    .target    (step_target),
    .nxt       (step_trip),
    .mid_macro (evt_mid_macro)
  );

  ufs_redirect u_redir (
    .rm_valid   (rm_valid),
    .cmt_valid  (cmt_sq_valid),
    .cmt_trip   (cmt_trip),
    .dec_valid  (dec_sq_valid),
    .dec_target (dec_target),
    .step_valid (step_valid),
    .step_trip  (step_trip),
    .load_trip  (load_trip),
    .src        (sel_src)
  );

  ufs_resolve u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .pred       (res_pred),
    .act        (res_act),
    .mispredict (mispredict),
    .mis_fields (mis_fields)
  );

  assign evt_redirect = (sel_src == SRC_REMOVE) || (sel_src == SRC_CMT) ||
                        (sel_src == SRC_DEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (sel_src != SRC_NONE) begin
      state_q <= load_trip;
    end
  end

  assign cur_pc    = state_q.pc;
  assign cur_npc   = state_q.npc;
  assign cur_upc   = state_q.upc;
  assign pred_pc   = step_trip.pc;
  assign pred_npc  = step_trip.npc;
  assign pred_upc  = step_trip.upc;
  assign line_step = (sel_src == SRC_STEP) && !evt_mid_macro;
endmodule

// File: rtl/ufetch_seq_chk.sv
module ufetch_seq_chk
  import ufs_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rm_valid,
  input logic               cmt_sq_valid,
  input logic [PC_W-1:0]    cmt_pc,
  input logic [PC_W-1:0]    cmt_npc,
  input logic [UPC_W-1:0]   cmt_upc,
  input logic               dec_sq_valid,
  input logic [PC_W-1:0]    dec_target,
  input logic               step_valid,
  input logic               step_is_ctrl,
  input logic               step_is_micro,
  input logic               step_is_last,
  input logic               step_taken,
  input logic [PC_W-1:0]    step_target,
  input logic               res_valid,
  input logic [PC_W-1:0]    res_pred_pc,
  input logic [PC_W-1:0]    res_act_pc,
  input logic [UPC_W-1:0]   res_pred_upc,
  input logic [UPC_W-1:0]   res_act_upc,
  input logic [PC_W-1:0]    cur_pc,
  input logic [PC_W-1:0]    cur_npc,
  input logic [UPC_W-1:0]   cur_upc,
  input logic               line_step,
  input logic               mispredict,
  input logic [NFIELDS-1:0] mis_fields,
  input logic               evt_redirect
);
  logic quiet;
  assign quiet = !rm_valid && !cmt_sq_valid && !dec_sq_valid;

  a_r2_micro_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && step_valid && !step_is_ctrl && step_is_micro && !step_is_last)
    |=> (cur_pc == $past(cur_pc) && cur_npc == $past(cur_npc) &&
         cur_upc == UPC_W'($past(cur_upc) + 1)));

  a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !step_is_ctrl && step_is_micro && !step_is_last) |-> !line_step);

  a_r3_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && step_valid && !step_is_ctrl && !(step_is_micro && !step_is_last))
    |=> (cur_pc == $past(cur_npc) && cur_npc == PC_W'($past(cur_npc) + 4) && cur_upc == '0));

  a_r4_ctrl_upc: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && step_valid && step_is_ctrl) |=> (cur_upc == '0));

  a_r5_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && step_valid && step_is_ctrl && step_taken)
    |=> (cur_pc == $past(cur_npc) && cur_npc == $past(step_target)));

  a_r7_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!rm_valid && cmt_sq_valid)
    |=> (cur_pc == $past(cmt_pc) && cur_npc == $past(cmt_npc) && cur_upc == $past(cmt_upc)));

  a_r7_no_line: assert property (@(posedge clk) disable iff (!rst_n)
    evt_redirect |-> !line_step);

  a_r8_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (!rm_valid && !cmt_sq_valid && dec_sq_valid)
    |=> (cur_pc == $past(dec_target) && cur_npc == PC_W'($past(dec_target) + 4) && cur_upc == '0));

  a_r9_remove: assert property (@(posedge clk) disable iff (!rst_n)
    rm_valid |=> (cur_pc == '0 && cur_npc == PC_W'(4) && cur_upc == '0));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (!mispredict && mis_fields == '0));

  a_r10_pc_field: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pred_pc != res_act_pc) |=> (mispredict && mis_fields[0]));

  a_r10_upc_field: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pred_upc != res_act_upc) |=> (mispredict && mis_fields[2]));

  a_r10_flag_mask: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict == (mis_fields != '0));
endmodule

bind ufetch_seq ufetch_seq_chk u_chk (.*);

// File: tb/ufetch_seq_test.sv
`timescale 1ns/1ps
module ufetch_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rm_valid = 0, cmt_sq_valid = 0, dec_sq_valid = 0;
  logic [31:0] cmt_pc = 0, cmt_npc = 0, dec_target = 0;
  logic [7:0]  cmt_upc = 0;
  logic        step_valid = 0, step_is_ctrl = 0, step_is_micro = 0, step_is_last = 0, step_taken = 0;
  logic [31:0] step_target = 0;
  logic        res_valid = 0;
  logic [31:0] res_pred_pc = 0, res_pred_npc = 0, res_act_pc = 0, res_act_npc = 0;
  logic [7:0]  res_pred_upc = 0, res_act_upc = 0;
  logic [31:0] cur_pc, cur_npc, pred_pc, pred_npc;
  logic [7:0]  cur_upc, pred_upc;
  logic        line_step, mispredict;
  logic [2:0]  mis_fields;

  int total = 0;
  int bad = 0;
  logic [31:0] m_pc = 0, m_npc = 0;
  logic [7:0]  m_upc = 0;

  always #4 clk = ~clk;

  ufetch_seq uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " pc"}, cur_pc, m_pc);
    chk({tag, " npc"}, cur_npc, m_npc);
    chk({tag, " upc"}, {24'd0, cur_upc}, {24'd0, m_upc});
  endtask

  // One step, checked before and after the edge. Inputs change on negedge.
  task automatic do_step(input string tag, input logic c, input logic mi, input logic la,
                         input logic tk, input logic [31:0] tg);
    logic [31:0] e_pc, e_npc;
    logic [7:0]  e_upc;
    logic        e_line;
    step_valid = 1; step_is_ctrl = c; step_is_micro = mi; step_is_last = la;
    step_taken = tk; step_target = tg;
    if (!c && mi && !la) begin
      e_pc = m_pc; e_npc = m_npc; e_upc = m_upc + 8'd1; e_line = 0;
    end else begin
      e_pc = m_npc; e_npc = (c && tk) ? tg : m_npc + 32'd4; e_upc = 0; e_line = 1;
    end
    #1;
    chk({tag, " R6 pred_pc"}, pred_pc, e_pc);
    chk({tag, " R6 pred_npc"}, pred_npc, e_npc);
    chk({tag, " R6 pred_upc"}, {24'd0, pred_upc}, {24'd0, e_upc});
    chk({tag, " line_step"}, {31'd0, line_step}, {31'd0, e_line});
    @(negedge clk);
    step_valid = 0;
    m_pc = e_pc; m_npc = e_npc; m_upc = e_upc;
    chk_state(tag);
  endtask

  task automatic t_reset;
    chk_state("R1 reset");
    chk("R1 mispredict", {31'd0, mispredict}, 0);
    chk("R1 mis_fields", {29'd0, mis_fields}, 0);
  endtask

  task automatic t_commit(input string tag, input logic with_dec, input logic with_step);
    cmt_sq_valid = 1; cmt_pc = 32'h100; cmt_npc = 32'h104; cmt_upc = 8'h05;
    dec_sq_valid = with_dec; dec_target = 32'h900;
    step_valid = with_step; step_is_ctrl = 0; step_is_micro = 0; step_is_last = 0;
    #1 chk({tag, " R7 line_step during redirect"}, {31'd0, line_step}, 0);
    @(negedge clk);
    cmt_sq_valid = 0; dec_sq_valid = 0; step_valid = 0;
    m_pc = 32'h100; m_npc = 32'h104; m_upc = 8'h05;
    chk_state({tag, " R7"});
  endtask

  task automatic t_macro;
    do_step("R3 plain", 0, 0, 0, 0, 0);
    do_step("R2 micro0", 0, 1, 0, 0, 0);
    do_step("R2 micro1", 0, 1, 0, 0, 0);
    do_step("R3 last micro", 0, 1, 1, 0, 0);
  endtask

  task automatic t_branch;
    do_step("R2 micro pre", 0, 1, 0, 0, 0);
    do_step("R4 ctrl in macro", 1, 1, 0, 0, 0);
    do_step("R5 taken", 1, 0, 0, 1, 32'h400);
    do_step("R5 delay then target", 0, 0, 0, 0, 0);
    chk("R5 landed", cur_pc, 32'h400);
  endtask

  task automatic t_decode;
    dec_sq_valid = 1; dec_target = 32'h800;
    step_valid = 1; step_is_ctrl = 0; step_is_micro = 0; step_is_last = 0;
    #1 chk("R8 line_step blocked", {31'd0, line_step}, 0);
    @(negedge clk);
    dec_sq_valid = 0; step_valid = 0;
    m_pc = 32'h800; m_npc = 32'h804; m_upc = 0;
    chk_state("R8 decode");
  endtask

  task automatic t_remove;
    rm_valid = 1; cmt_sq_valid = 1; cmt_pc = 32'h55; cmt_npc = 32'h59; cmt_upc = 3;
    dec_sq_valid = 1; dec_target = 32'h700; step_valid = 1;
    @(negedge clk);
    rm_valid = 0; cmt_sq_valid = 0; dec_sq_valid = 0; step_valid = 0;
    m_pc = 0; m_npc = 4; m_upc = 0;
    chk_state("R9 remove");
  endtask

  task automatic t_resolve(input string tag, input logic [31:0] ppc, input logic [7:0] pupc,
                           input logic [31:0] apc, input logic [7:0] aupc, input logic [2:0] exp_f);
    res_valid = 1; res_pred_pc = ppc; res_pred_npc = 32'h20; res_pred_upc = pupc;
    res_act_pc = apc; res_act_npc = 32'h20; res_act_upc = aupc;
    #1 chk({tag, " R10 no early flag"}, {31'd0, mispredict}, 0);
    @(negedge clk);
    res_valid = 0;
    chk({tag, " R10 flag"}, {31'd0, mispredict}, {31'd0, exp_f != 3'b0});
    chk({tag, " R10 fields"}, {29'd0, mis_fields}, {29'd0, exp_f});
    @(negedge clk);
    chk({tag, " R10 cleared"}, {31'd0, mispredict}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_commit("commit only", 0, 0);
        t_macro();
        t_branch();
        t_decode();
        t_commit("commit over decode", 1, 1);
        t_remove();
        t_resolve("match", 32'h10, 8'd2, 32'h10, 8'd2, 3'b000);
        t_resolve("upc only", 32'h10, 8'd2, 32'h10, 8'd0, 3'b100);
        t_resolve("pc only", 32'h10, 8'd0, 32'h14, 8'd0, 3'b001);
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule